// File: doc/BRIEF.md
# Gap-Modulated Low-Frequency Downlink Transmitter

This block keys the carrier enable of a 125 kHz reader field so that a low-frequency tag receives a downlink command as a pattern of field-off gaps. Durations are counted in carrier periods by a one-cycle `tick` strobe. An upstream builder offers the command one symbol at a time over a valid/ready handshake with a last flag. The block produces the field-off start gap, an optional long reference pulse, one field-on interval per symbol followed by a field-off write gap, and a closing field-on read gap. It then pulses `done` and leaves the field on for the tag's answer.

A frame begins when a symbol is offered while the block is idle. The mode selector is sampled at that moment and fixes the timing scheme for the whole frame. There are four schemes: fixed bit length, long leading reference, leading zero, and 1-of-4 pulse position, in which each symbol carries two bits. Building the command bits, demodulating the answer and generating the carrier are outside this block.

Top module: `gapmod_downlink_tx`

## Requirements
- R1: While reset is held and after it is released, `field_on`, `sym_ready` and `done` are all 0.
- R2: A frame starts when `sym_valid` is 1 while idle. `mode_sel` is captured at that edge, and later changes to it have no effect on the frame. The field is then off for 31 ticks.
- R3: Every sent symbol is a field-on interval followed by a field-off write gap of 20 ticks.
- R4: In fixed mode (code 0) and long-reference mode (code 1), `sym_data[0]` is the bit: 0 gives 18 on-ticks and 1 gives 50. `sym_data[1]` is ignored.
- R5: In leading-zero mode (code 2), `sym_data[0]`=0 gives 18 on-ticks and 1 gives 40.
- R6: In 1-of-4 mode (code 3), `sym_data[1]` is the earlier bit (MSB) of the pair. The values 00, 01, 10 and 11 give 18, 34, 50 and 66 on-ticks.
- R7: In long-reference mode, the start gap is followed by a reference pulse of 154 on-ticks (the 0 on-time plus 136) and a 20-tick off gap, before the first symbol.
- R8: With `mode_sel` 3 bits wide, the codes 4 to 7 behave exactly like fixed mode.
- R9: After the write gap of the last symbol, the field is on for 15 ticks. `done` then pulses high for one cycle, and the field stays on while idle.
- R10: In 1-of-4 mode, a beat with both `sym_last` and `sym_odd` set carries an unpaired bit. It is accepted but sends no symbol, and the read gap follows. In other modes `sym_odd` has no effect.
- R11: `sym_ready` is 1 only while waiting for the next symbol, once the start gap (and the reference) or the previous write gap has ended. An accepted symbol turns the field on in the next cycle.
- R12: All durations advance only on cycles with `tick`=1. With `tick` held low, `field_on` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe per carrier period |
| mode_sel | input | MODE_W (3) | Timing scheme code, sampled at frame start |
| sym_valid | input | 1 | Symbol offered; starts a frame when idle |
| sym_ready | output | 1 | Block takes the offered symbol this cycle |
| sym_data | input | 2 | Symbol bits; bit 1 is the earlier bit of a 1-of-4 pair |
| sym_last | input | 1 | Offered symbol is the last of the frame |
| sym_odd | input | 1 | Last beat of a 1-of-4 frame holds only an unpaired bit |
| field_on | output | 1 | Carrier enable |
| done | output | 1 | One-cycle pulse at the end of the read gap |

## Verification
The bench sweeps all eight mode codes over every 2-bit symbol value. It counts ticks per field level and compares each run with lengths computed from the requirements. A design that counted clock cycles instead of ticks would return runs three times too long. A design that decoded a mode wrongly, or swapped the bit order of a pair, would show wrong on-lengths. A design that left out the reference pulse, or sent it in the wrong mode, would show an extra or a missing run. Further frames drop an unpaired trailing bit (and keep it outside 1-of-4 mode), change the mode selector in the middle of a frame, and stall the tick inside a pulse. An incorrect design would send a stray pulse, switch timing partway through the frame, or move the field while no tick arrives.

// File: rtl/gapmod_pkg.sv
package gapmod_pkg;

   typedef enum logic [1:0] {
      DL_FIXED = 2'd0,
      DL_LLR   = 2'd1,
      DL_LZ    = 2'd2,
      DL_QUAD  = 2'd3
   } dl_mode_e;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_START,
      TX_REF_ON,
      TX_REF_GAP,
      TX_WAIT,
      TX_SYM_ON,
      TX_SYM_GAP,
      TX_READ_ON
   } tx_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/gapmod_interval.sv
// Tick-driven down counter: load a duration, expire on the tick that ends it.
module gapmod_interval #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expire
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (tick && (cnt_q != '0))
         cnt_q <= cnt_q - W'(1);
   end

   assign expire = tick && (cnt_q == W'(1));
endmodule

// File: rtl/gapmod_symtime.sv
// Field-on duration of one symbol for the captured timing scheme.
module gapmod_symtime import gapmod_pkg::*; #(
   parameter int W       = 8,
   parameter int ON_0    = 18,
   parameter int ON_1    = 50,
   parameter int ON_1_LZ = 40,
   parameter int ON_Q1   = 34,
   parameter int ON_Q2   = 50,
   parameter int ON_Q3   = 66,
   parameter bit QUAD_EN = 1'b1
) (
   input  dl_mode_e     mode,
   input  logic [1:0]   bits,
   output logic [W-1:0] dur
);
   logic [W-1:0] bin_dur;

   always_comb begin
      if (!bits[0])
         bin_dur = W'(ON_0);
      else if (mode == DL_LZ)
         bin_dur = W'(ON_1_LZ);
      else
         bin_dur = W'(ON_1);
   end

   generate
      if (QUAD_EN) begin : g_quad
         logic [W-1:0] quad_dur;
         always_comb begin
            unique case (bits)
               2'b00:   quad_dur = W'(ON_0);
               2'b01:   quad_dur = W'(ON_Q1);
               2'b10:   quad_dur = W'(ON_Q2);
               default: quad_dur = W'(ON_Q3);
            endcase
         end
         assign dur = (mode == DL_QUAD) ? quad_dur : bin_dur;
      end else begin : g_bin
         assign dur = bin_dur;
      end
   endgenerate
endmodule

// File: rtl/gapmod_downlink_tx.sv
module gapmod_downlink_tx import gapmod_pkg::*; #(
   parameter int MODE_W    = 3,
   parameter int START_GAP = 31,
   parameter int WR_GAP    = 20,
   parameter int ON_0      = 18,
   parameter int ON_1      = 50,
   parameter int ON_1_LZ   = 40,
   parameter int ON_Q1     = 34,
   parameter int ON_Q2     = 50,
   parameter int ON_Q3     = 66,
   parameter int REF_EXTRA = 136,
   parameter int READ_GAP  = 15,
   parameter bit QUAD_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              sym_valid,
   output logic              sym_ready,
   input  logic [1:0]        sym_data,
   input  logic              sym_last,
   input  logic              sym_odd,
   output logic              field_on,
   output logic              done
);
   localparam int REF_ON = ON_0 + REF_EXTRA;
   localparam int MAXD   = max2(max2(max2(START_GAP, REF_ON), max2(WR_GAP, READ_GAP)),
                                max2(max2(ON_1, ON_1_LZ), max2(ON_Q1, max2(ON_Q2, ON_Q3))));
   localparam int CNT_W  = $clog2(MAXD + 1);

   generate
      if (MODE_W < 2) begin : g_bad_mode_w
         $error("MODE_W must be at least 2");
      end
      if (START_GAP < 1 || WR_GAP < 1 || READ_GAP < 1 || ON_0 < 1) begin : g_bad_gap
         $error("all gap and on durations must be at least one tick");
      end
      if (ON_1 <= ON_0 || ON_1_LZ <= ON_0) begin : g_bad_bin
         $error("a one must be longer than a zero");
      end
      if (QUAD_EN && !(ON_0 < ON_Q1 && ON_Q1 < ON_Q2 && ON_Q2 < ON_Q3)) begin : g_bad_quad
         $error("pulse-position durations must rise strictly");
      end
   endgenerate

   tx_state_e          st_q, st_nx;
   dl_mode_e           mode_q, mode_dec;
   logic               field_q, field_nx;
   logic               done_q, done_nx;
   logic               last_q;
   logic               cap_mode, cap_last, drop_beat;
   logic               ld;
   logic [CNT_W-1:0]   ld_val, sym_dur;
   logic               expire;

   always_comb begin
      if (mode_sel == MODE_W'(1))
         mode_dec = DL_LLR;
      else if (mode_sel == MODE_W'(2))
         mode_dec = DL_LZ;
      else if (mode_sel == MODE_W'(3) && QUAD_EN)
         mode_dec = DL_QUAD;
      else
         mode_dec = DL_FIXED;
   end

   gapmod_symtime #(
      .W(CNT_W), .ON_0(ON_0), .ON_1(ON_1), .ON_1_LZ(ON_1_LZ),
      .ON_Q1(ON_Q1), .ON_Q2(ON_Q2), .ON_Q3(ON_Q3), .QUAD_EN(QUAD_EN)
   ) symtime_i (
      .mode(mode_q),
      .bits(sym_data),
      .dur (sym_dur)
   );

   gapmod_interval #(.W(CNT_W)) interval_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .load    (ld),
      .load_val(ld_val),
      .expire  (expire)
   );

   assign drop_beat = (mode_q == DL_QUAD) && sym_odd && sym_last;

   always_comb begin
      st_nx    = st_q;
      field_nx = field_q;
      done_nx  = 1'b0;
      ld       = 1'b0;
      ld_val   = '0;
      cap_mode = 1'b0;
      cap_last = 1'b0;
      unique case (st_q)
         TX_IDLE: begin
            if (sym_valid) begin
               st_nx    = TX_START;
               field_nx = 1'b0;
               ld       = 1'b1;
               ld_val   = CNT_W'(START_GAP);
               cap_mode = 1'b1;
            end
         end
         TX_START: begin
            if (expire) begin
               if (mode_q == DL_LLR) begin
                  st_nx    = TX_REF_ON;
                  field_nx = 1'b1;
                  ld       = 1'b1;
                  ld_val   = CNT_W'(REF_ON);
               end else begin
                  st_nx = TX_WAIT;
               end
            end
         end
         TX_REF_ON: begin
            if (expire) begin
               st_nx    = TX_REF_GAP;
               field_nx = 1'b0;
               ld       = 1'b1;
               ld_val   = CNT_W'(WR_GAP);
            end
         end
         TX_REF_GAP: begin
            if (expire) st_nx = TX_WAIT;
         end
         TX_WAIT: begin
            if (sym_valid) begin
               cap_last = 1'b1;
               field_nx = 1'b1;
               ld       = 1'b1;
               if (drop_beat) begin
                  st_nx  = TX_READ_ON;
                  ld_val = CNT_W'(READ_GAP);
               end else begin
                  st_nx  = TX_SYM_ON;
                  ld_val = sym_dur;
               end
            end
         end
         TX_SYM_ON: begin
            if (expire) begin
               st_nx    = TX_SYM_GAP;
               field_nx = 1'b0;
               ld       = 1'b1;
               ld_val   = CNT_W'(WR_GAP);
            end
         end
         TX_SYM_GAP: begin
            if (expire) begin
               if (last_q) begin
                  st_nx    = TX_READ_ON;
                  field_nx = 1'b1;
                  ld       = 1'b1;
                  ld_val   = CNT_W'(READ_GAP);
               end else begin
                  st_nx = TX_WAIT;
               end
            end
         end
         TX_READ_ON: begin
            if (expire) begin
               st_nx   = TX_IDLE;
               done_nx = 1'b1;
            end
         end
         default: st_nx = TX_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= TX_IDLE;
         mode_q  <= DL_FIXED;
         field_q <= 1'b0;
         done_q  <= 1'b0;
         last_q  <= 1'b0;
      end else begin
         st_q    <= st_nx;
         field_q <= field_nx;
         done_q  <= done_nx;
         if (cap_mode) mode_q <= mode_dec;
         if (cap_last) last_q <= sym_last;
      end
   end

   assign sym_ready = (st_q == TX_WAIT);
   assign field_on  = field_q;
   assign done      = done_q;
endmodule

// File: rtl/gapmod_downlink_tx_chk.sv
module gapmod_downlink_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic sym_valid,
   input logic sym_ready,
   input logic field_on,
   input logic done
);
   // R11: the handshake only opens while the field is off between symbols
   assert_ready_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sym_ready |-> (!field_on && !done));

   // R11: a taken beat turns the field on in the following cycle
   assert_accept_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_ready) |=> field_on);

   // R9: done lasts a single cycle
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: the field is on at done and stays on afterwards
   assert_done_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (field_on && !sym_ready));
   assert_hold_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> field_on);

   // R12: the field drops only when a duration ends on a tick or a frame begins
   assert_fall_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(field_on) |-> ($past(tick) || $past(sym_valid && !sym_ready)));

   // R12: the field rises only when a duration ends on a tick or a beat is taken
   assert_rise_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(field_on) |-> ($past(tick) || $past(sym_valid && sym_ready)));
endmodule

bind gapmod_downlink_tx gapmod_downlink_tx_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .sym_valid(sym_valid),
   .sym_ready(sym_ready),
   .field_on (field_on),
   .done     (done)
);

// File: tb/gapmod_downlink_tx_tb_top.sv
module gapmod_downlink_tx_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       tick_en = 1'b1;
   logic [2:0] mode_sel = '0;
   logic       sym_valid = 1'b0;
   logic       sym_ready;
   logic [1:0] sym_data = '0;
   logic       sym_last = 1'b0;
   logic       sym_odd = 1'b0;
   logic       field_on;
   logic       done;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int div = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gapmod_downlink_tx dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel),
      .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data),
      .sym_last(sym_last), .sym_odd(sym_odd), .field_on(field_on), .done(done)
   );

   // tick every third cycle, frozen while tick_en is low
   always @(posedge clk) begin
      div  <= (div == 2) ? 0 : div + 1;
      tick <= tick_en && (div == 2);
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WDOG_CYC) begin
         errors++;
         checks++;
         $display("FAIL R9 watchdog actual=%0d expected=done before limit", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // run-length monitor counted in ticks
   int    r_val[64];
   int    r_len[64];
   int    nruns;
   int    prevv;
   int    curlen;
   bit    arm = 0;
   bit    collecting = 0;
   bit    frame_done = 0;
   int    bad_rdy = 0;

   always @(negedge clk) begin
      if (arm) begin
         nruns = 0; prevv = -1; curlen = 0; collecting = 1; arm = 0; bad_rdy = 0;
      end else if (collecting) begin
         if (sym_ready && field_on) bad_rdy++;
         if (done) begin
            if (nruns < 64) begin r_val[nruns] = prevv; r_len[nruns] = curlen; nruns++; end
            collecting = 0;
            frame_done = 1;
         end else begin
            if (int'(field_on) != prevv) begin
               if (prevv >= 0 && nruns < 64) begin
                  r_val[nruns] = prevv; r_len[nruns] = curlen; nruns++;
               end
               prevv = int'(field_on);
               curlen = 0;
            end
            if (tick) curlen++;
         end
      end
   end

   // expected runs
   int    e_val[64];
   int    e_len[64];
   string e_tag[64];
   int    ne;
   int    sq[8];

   function automatic int exp_on(input int m, input int d);
      if (m == 3) begin
         case (d)
            0: return 18;
            1: return 34;
            2: return 50;
            default: return 66;
         endcase
      end
      if ((d & 1) == 0) return 18;
      return (m == 2) ? 40 : 50;
   endfunction

   function automatic string mode_tag(input int m);
      case (m)
         0: return "R4";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic add_run(input int v, input int l, input string t);
      e_val[ne] = v; e_len[ne] = l; e_tag[ne] = t; ne++;
   endtask

   task automatic run_frame(input int m, input int n, input bit oddlast,
                            input int m_after, input bit pause);
      int v;
      bit stable;
      ne = 0;
      add_run(0, 31, "R2");
      if (m == 1) begin
         add_run(1, 154, "R7");
         add_run(0, 20, "R7");
      end
      for (int i = 0; i < n; i++) begin
         if (!(m == 3 && oddlast && i == n - 1)) begin
            add_run(1, exp_on(m, sq[i]), mode_tag(m));
            add_run(0, 20, "R3");
         end
      end
      add_run(1, 15, "R9");

      @(posedge clk); #1;
      frame_done = 0;
      mode_sel  = 3'(m);
      arm       = 1;
      sym_valid = 1;
      for (int i = 0; i < n; i++) begin
         sym_data = 2'(sq[i]);
         sym_last = (i == n - 1);
         sym_odd  = oddlast && (i == n - 1);
         @(negedge clk);
         while (!sym_ready) @(negedge clk);
         @(posedge clk); #1;
         if (i == 0) mode_sel = 3'(m_after);
         if (pause && i == 0) begin
            tick_en = 0;
            @(negedge clk);
            v = int'(field_on);
            stable = 1;
            repeat (30) begin
               @(negedge clk);
               if (int'(field_on) != v) stable = 0;
            end
            chk(stable && v == 1, "R12", "field frozen without tick", int'(field_on), 1);
            @(posedge clk); #1;
            tick_en = 1;
         end
      end
      sym_valid = 0;
      sym_last  = 0;
      sym_odd   = 0;
      while (!frame_done) @(negedge clk);

      chk(nruns == ne, "R3", "run count", nruns, ne);
      for (int k = 0; k < ne && k < nruns; k++) begin
         chk(r_val[k] == e_val[k], e_tag[k], $sformatf("run %0d level", k), r_val[k], e_val[k]);
         chk(r_len[k] == e_len[k], e_tag[k], $sformatf("run %0d ticks", k), r_len[k], e_len[k]);
      end
      chk(bad_rdy == 0, "R11", "ready while field on", bad_rdy, 0);
      @(negedge clk);
      chk(done == 0, "R9", "done one cycle", int'(done), 0);
      chk(field_on == 1, "R9", "field held on after done", int'(field_on), 1);
      chk(sym_ready == 0, "R11", "ready low in idle", int'(sym_ready), 0);
      repeat (4) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk(field_on == 0 && sym_ready == 0 && done == 0, "R1", "outputs in reset",
          int'({field_on, sym_ready, done}), 0);
      @(posedge clk); #1;
      rst_n = 1;
      repeat (5) @(negedge clk);
      chk(field_on == 0, "R1", "field off after reset", int'(field_on), 0);
      chk(sym_ready == 0, "R1", "ready low after reset", int'(sym_ready), 0);
      chk(done == 0, "R1", "done low after reset", int'(done), 0);

      // sweep all eight mode codes over every symbol value (R4 R5 R6 R7 R8)
      sq[0] = 0; sq[1] = 1; sq[2] = 2; sq[3] = 3;
      for (int m = 0; m < 8; m++) run_frame(m, 4, 0, m, 0);

      // R10: unpaired trailing bit dropped in 1-of-4
      sq[0] = 3; sq[1] = 1; sq[2] = 2;
      run_frame(3, 3, 1, 3, 0);
      // R10: frame made of one unpaired bit only
      sq[0] = 2;
      run_frame(3, 1, 1, 3, 0);
      // R10: odd flag ignored outside 1-of-4
      sq[0] = 1; sq[1] = 0;
      run_frame(0, 2, 1, 0, 0);
      run_frame(2, 2, 1, 2, 0);

      // R2: mode change after frame start ignored
      sq[0] = 1; sq[1] = 1; sq[2] = 0;
      run_frame(2, 3, 0, 3, 0);
      run_frame(0, 3, 0, 1, 0);

      // R12: tick stall inside a pulse, long-reference frame
      sq[0] = 1; sq[1] = 0;
      run_frame(1, 2, 0, 1, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule